// File: doc/BRIEF.md
# Partial Bitstream Stream Loader

This block is a small sequencer that reconfigures part of the device without a processor. It copies a partial configuration image from an external parallel flash into the on-chip configuration access port, one byte per clock. A start pulse latches a flash start address and a payload length. The loader then writes an 8-byte synchronization preamble to the port, forwards the payload bytes read from flash, and appends a fixed 16-byte desynchronization trailer. It then watches the port's busy status and reports completion once that status has returned to idle.

The flash side is a valid/ready stream. The loader raises `fl_ready` only while it streams the payload. A byte moves on every clock edge where both `fl_valid` and `fl_ready` are high. When `fl_valid` is low the loader waits: it neither advances the address nor writes to the port. The port side has no back-pressure. A byte is written on every clock where the active-low strobes are low. Flash data reaches the port combinationally, so a flash byte costs no extra cycle. A cycle budget, 40 ms at 33 MHz by default, guards the whole load. When it runs out the loader stops in a sticky error state that only reset clears.

Top module: `prl_loader`

## Requirements
- R1: After a synchronous active-high reset, `busy`, `done` and `err` are 0, `fl_ready` is 0 and both `cfg_ce_n` and `cfg_we_n` are 1.
- R2: Each load first writes 8 preamble bytes to the port. In logical order these are FF FF FF FF AA 99 55 66, the most significant byte of each 32-bit word first.
- R3: After the preamble the payload follows, `len_bytes` bytes read from flash addresses `base_addr`, `base_addr`+1, and so on. The address steps by exactly one per accepted byte.
- R4: After the payload the loader writes 16 trailer bytes. In logical order these are 30 00 80 01 00 00 00 0D 20 00 00 00 20 00 00 00.
- R5: Every byte on `cfg_data` is bit-reversed: logical bit 7 appears on `cfg_data[0]` and logical bit 0 on `cfg_data[7]`.
- R6: When `fl_valid` is low during the payload, no byte is written to the port and the flash address holds, so no byte is dropped or repeated.
- R7: After the trailer, `done` stays 0 while `cfg_busy` is 1. `done` rises on the clock after `cfg_busy` is seen low, and `busy` then falls.
- R8: If more than `CYCLE_LIMIT` cycles pass after the start edge before completion, `err` is set on the following edge. `err` then stays set until reset, and no further port strobes occur.
- R9: `start` is accepted only when the loader is idle or done. A start during a load has no effect on the bytes written, and a start while in error leaves `err` high and the port strobes high.
- R10: With `len_bytes` = 0, the trailer follows the preamble directly.
- R11: `cfg_ce_n` and `cfg_we_n` are low only during the preamble, payload and trailer phases, and `fl_ready` is high only during the payload phase.
- R12: `len_bytes` and `base_addr` are latched at the accepted start. Changing them during a load does not change the bytes written.
- R13: Reset clears a sticky error, and a new load can then complete.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Loader clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Load request, sampled on the clock edge |
| len_bytes | input | LEN_W | Payload length in bytes, latched at start |
| base_addr | input | ADDR_W | First flash address, latched at start |
| fl_addr | output | ADDR_W | Flash read address |
| fl_data | input | 8 | Flash read byte |
| fl_valid | input | 1 | Flash byte at `fl_addr` is valid |
| fl_ready | output | 1 | Loader takes a flash byte this cycle |
| cfg_data | output | 8 | Bit-reversed byte to configuration port |
| cfg_ce_n | output | 1 | Port chip enable, active low |
| cfg_we_n | output | 1 | Port write enable, active low |
| cfg_busy | input | 1 | Port status, high while reconfiguring |
| busy | output | 1 | Load in progress |
| done | output | 1 | Last load finished |
| err | output | 1 | Cycle budget exceeded (sticky) |

## Verification
Loads are run with an always-valid flash, with a flash that is valid on alternate cycles, and with a flash that delivers irregular bursts. Comparing these shows whether a stall cycle drops, repeats or shifts a payload byte. A zero-length load separates the preamble and trailer logic from the payload path. A load run while its inputs are changed and a second start is pulsed shows that the inputs are latched and that mid-load starts are ignored. Holding the port status busy for several cycles, and in one run forever, tells completion by status apart from completion by byte count, and exercises the budget error.

// File: rtl/prl_pkg.sv
package prl_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_SYNC, ST_LOAD, ST_DESYNC, ST_WAIT, ST_DONE, ST_ERROR
  } prl_state_e;

  localparam int PRE_BYTES = 8;
  localparam int TRL_BYTES = 16;
  localparam int IDX_W     = $clog2(TRL_BYTES);

  // configuration port expects bit 0 of each byte on its most significant lane
  function automatic logic [7:0] flip8(input logic [7:0] b);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = b[7-i];
    return r;
  endfunction
endpackage

// File: rtl/prl_seq_rom.sv
module prl_seq_rom
  import prl_pkg::*;
(
  input  logic             sel_trailer,
  input  logic [IDX_W-1:0] idx,
  output logic [7:0]       byte_o
);
  logic [31:0] word;

  always_comb begin
    if (!sel_trailer) begin
      word = idx[2] ? 32'hAA99_5566 : 32'hFFFF_FFFF;
    end else begin
      unique case (idx[3:2])
        2'd0:    word = 32'h3000_8001;
        2'd1:    word = 32'h0000_000D;
        default: word = 32'h2000_0000;
      endcase
    end
    // most significant byte of each word leaves first
    byte_o = word[8*(3 - idx[1:0]) +: 8];
  end
endmodule

// File: rtl/prl_budget_timer.sv
module prl_budget_timer #(
  parameter int CYCLE_LIMIT = 1_320_000
) (
  input  logic clk,
  input  logic rst,
  input  logic clear,
  input  logic run,
  output logic expired
);
  localparam int CW = $clog2(CYCLE_LIMIT + 1);
  localparam logic [CW-1:0] LIM = CW'(CYCLE_LIMIT);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst || clear)          cnt <= '0;
    else if (run && cnt < LIM) cnt <= cnt + 1'b1;
  end

  assign expired = (cnt >= LIM);

  AST_TIMER_BOUND: assert property (@(posedge clk) disable iff (rst)
    cnt <= LIM); // R8
endmodule

// File: rtl/prl_stream_ctr.sv
module prl_stream_ctr #(
  parameter int ADDR_W = 24,
  parameter int LEN_W  = 20
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [ADDR_W-1:0] base,
  input  logic [LEN_W-1:0]  len,
  input  logic              step,
  output logic [ADDR_W-1:0] addr,
  output logic              rem_one,
  output logic              rem_zero
);
  logic [LEN_W-1:0] rem;

  always_ff @(posedge clk) begin
    if (rst) begin
      addr <= '0;
      rem  <= '0;
    end else if (load) begin
      addr <= base;
      rem  <= len;
    end else if (step) begin
      addr <= addr + 1'b1;
      rem  <= rem - 1'b1;
    end
  end

  assign rem_one  = (rem == LEN_W'(1));
  assign rem_zero = (rem == '0);

  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
    step |-> !rem_zero); // R3
endmodule

// File: rtl/prl_loader.sv
module prl_loader
  import prl_pkg::*;
#(
  parameter int ADDR_W      = 24,
  parameter int LEN_W       = 20,
  parameter int CYCLE_LIMIT = 1_320_000
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [LEN_W-1:0]  len_bytes,
  input  logic [ADDR_W-1:0] base_addr,
  output logic [ADDR_W-1:0] fl_addr,
  input  logic [7:0]        fl_data,
  input  logic              fl_valid,
  output logic              fl_ready,
  output logic [7:0]        cfg_data,
  output logic              cfg_ce_n,
  output logic              cfg_we_n,
  input  logic              cfg_busy,
  output logic              busy,
  output logic              done,
  output logic              err
);
  prl_state_e       state, state_nx;
  logic [IDX_W-1:0] idx;
  logic [7:0]       rom_byte;
  logic             accept, start_ok, active, emit;
  logic             rem_one, rem_zero, expired;
  logic             last_pre, last_trl;

  assign active   = (state == ST_SYNC) || (state == ST_LOAD) ||
                    (state == ST_DESYNC) || (state == ST_WAIT);
  assign start_ok = start && ((state == ST_IDLE) || (state == ST_DONE));
  assign fl_ready = (state == ST_LOAD);
  assign accept   = fl_ready && fl_valid;
  assign last_pre = (idx == IDX_W'(PRE_BYTES - 1));
  assign last_trl = (idx == IDX_W'(TRL_BYTES - 1));

  prl_seq_rom u_rom (
    .sel_trailer (state == ST_DESYNC),
    .idx         (idx),
    .byte_o      (rom_byte)
  );

  prl_budget_timer #(.CYCLE_LIMIT(CYCLE_LIMIT)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .clear   (start_ok),
    .run     (active),
    .expired (expired)
  );

  prl_stream_ctr #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_ctr (
    .clk      (clk),
    .rst      (rst),
    .load     (start_ok),
    .base     (base_addr),
    .len      (len_bytes),
    .step     (accept),
    .addr     (fl_addr),
    .rem_one  (rem_one),
    .rem_zero (rem_zero)
  );

  always_comb begin
    state_nx = state;
    if (active && expired) begin
      state_nx = ST_ERROR;
    end else begin
      unique case (state)
        ST_IDLE, ST_DONE: if (start) state_nx = ST_SYNC;
        ST_SYNC:   if (last_pre) state_nx = rem_zero ? ST_DESYNC : ST_LOAD;
        ST_LOAD:   if (accept && rem_one) state_nx = ST_DESYNC;
        ST_DESYNC: if (last_trl) state_nx = ST_WAIT;
        ST_WAIT:   if (!cfg_busy) state_nx = ST_DONE;
        default:   state_nx = state;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      idx   <= '0;
    end else begin
      state <= state_nx;
      if (state_nx != state) idx <= '0;
      else if ((state == ST_SYNC) || (state == ST_DESYNC)) idx <= idx + 1'b1;
    end
  end

  assign emit     = (state == ST_SYNC) || (state == ST_DESYNC) || accept;
  assign cfg_ce_n = !emit;
  assign cfg_we_n = !emit;
  assign cfg_data = flip8((state == ST_LOAD) ? fl_data : rom_byte);
  assign busy     = active;
  assign done     = (state == ST_DONE);
  assign err      = (state == ST_ERROR);

  AST_STROBE_IN_PHASE: assert property (@(posedge clk) disable iff (rst)
    !cfg_ce_n |-> (state == ST_SYNC || state == ST_LOAD || state == ST_DESYNC)); // R11
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (rst)
    (fl_valid && fl_ready) |=> (fl_addr == $past(fl_addr) + 1'b1)); // R3
  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (rst)
    (fl_ready && !fl_valid) |-> cfg_ce_n ##1 $stable(fl_addr)); // R6
  AST_DONE_ON_IDLE: assert property (@(posedge clk) disable iff (rst)
    $rose(done) |-> $past(!cfg_busy)); // R7
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    err |=> err && cfg_ce_n); // R8
  AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (rst)
    $countones({busy, done, err}) <= 1); // R1
endmodule

// File: tb/tb_prl_loader.sv
module tb_prl_loader;
  localparam int AW = 24, LW = 20, LIMIT = 200;

  logic clk = 1'b0, rst = 1'b1, start = 1'b0;
  logic [LW-1:0] len_bytes = '0;
  logic [AW-1:0] base_addr = '0;
  logic [AW-1:0] fl_addr;
  logic [7:0]    fl_data, cfg_data;
  logic fl_valid = 1'b1, fl_ready, cfg_ce_n, cfg_we_n, cfg_busy = 1'b0;
  logic busy, done, err;

  int checks = 0, fails = 0, cyc = 0, vmode = 0, ncap = 0;
  logic [7:0] cap [0:127];

  prl_loader #(.ADDR_W(AW), .LEN_W(LW), .CYCLE_LIMIT(LIMIT)) dut (
    .clk(clk), .rst(rst), .start(start), .len_bytes(len_bytes),
    .base_addr(base_addr), .fl_addr(fl_addr), .fl_data(fl_data),
    .fl_valid(fl_valid), .fl_ready(fl_ready), .cfg_data(cfg_data),
    .cfg_ce_n(cfg_ce_n), .cfg_we_n(cfg_we_n), .cfg_busy(cfg_busy),
    .busy(busy), .done(done), .err(err));

  always #5 clk = ~clk;

  function automatic logic [7:0] fgen(input logic [AW-1:0] a);
    return 8'((a * 37 + 11) ^ (a >> 8));
  endfunction
  assign fl_data = fgen(fl_addr);

  function automatic logic [7:0] rev8(input logic [7:0] b);
    return {b[0], b[1], b[2], b[3], b[4], b[5], b[6], b[7]};
  endfunction

  function automatic logic [7:0] exp_byte(input int i, input int len, input logic [AW-1:0] base);
    logic [7:0] pre [0:7];
    logic [7:0] trl [0:15];
    pre = '{8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hAA, 8'h99, 8'h55, 8'h66};
    trl = '{8'h30, 8'h00, 8'h80, 8'h01, 8'h00, 8'h00, 8'h00, 8'h0D,
            8'h20, 8'h00, 8'h00, 8'h00, 8'h20, 8'h00, 8'h00, 8'h00};
    if (i < 8) return rev8(pre[i]);
    if (i < 8 + len) return rev8(fgen(base + AW'(i - 8)));
    return rev8(trl[i - 8 - len]);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // port model: record each strobed byte
  always @(negedge clk) begin
    cyc++;
    if (!rst && !cfg_ce_n) begin
      if (cfg_we_n !== 1'b0) begin
        checks++; fails++;
        $display("FAIL R11 actual we_n=%0b expected=0", cfg_we_n);
      end
      if (ncap < 128) cap[ncap] = cfg_data;
      ncap++;
    end
    if (!rst && fl_ready && !(dut.busy)) begin
      checks++; fails++;
      $display("FAIL R11 actual fl_ready=1 expected=0 while not busy");
    end
  end

  // flash valid patterns
  always @(posedge clk) begin
    #1;
    case (vmode)
      0: fl_valid = 1'b1;
      1: fl_valid = cyc[0];
      default: fl_valid = ((cyc % 7) < 3) || ((cyc % 5) == 4);
    endcase
  end

  task automatic pulse_start();
    @(posedge clk); #1 start = 1'b1;
    @(posedge clk); #1 start = 1'b0;
  endtask

  task automatic run_load(input string tag, input int len, input logic [AW-1:0] base,
                          input int mode, input int tail, input bit intrude);
    int total = 8 + len + 16;
    int guard = 0;
    vmode = mode; ncap = 0; cfg_busy = 1'b1;
    len_bytes = LW'(len); base_addr = base;
    pulse_start();
    if (intrude) begin
      repeat (3) @(negedge clk);
      len_bytes = LW'(len + 9); base_addr = base + 24'h40;   // R12
      start = 1'b1; @(negedge clk); start = 1'b0;             // R9
    end
    while (ncap < total && guard < 1000) begin @(negedge clk); guard++; end
    repeat (2) @(negedge clk);
    check({tag, " R3 byte count"}, ncap, total);
    for (int k = 0; k < tail; k++) begin
      @(negedge clk);
      check({tag, " R7 done held while port busy"}, done, 0);
    end
    cfg_busy = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check({tag, " R7 done after status idle"}, done, 1);
    check({tag, " R7 busy cleared"}, busy, 0);
    for (int i = 0; i < total && i < 128; i++)
      check($sformatf("%s R2 R3 R4 R5 byte %0d", tag, i), cap[i], exp_byte(i, len, base));
  endtask

  task automatic t_reset();
    check("R1 busy", busy, 0);
    check("R1 done", done, 0);
    check("R1 err", err, 0);
    check("R1 fl_ready", fl_ready, 0);
    check("R1 ce_n", cfg_ce_n, 1);
    check("R1 we_n", cfg_we_n, 1);
  endtask

  task automatic t_timeout();
    vmode = 0; ncap = 0; cfg_busy = 1'b1;
    len_bytes = LW'(4); base_addr = 24'h000100;
    pulse_start();
    repeat (LIMIT + 1) @(negedge clk);
    check("R8 no error at budget", err, 0);
    @(negedge clk);
    check("R8 error past budget", err, 1);
    check("R8 done low on error", done, 0);
    ncap = 0;
    pulse_start();
    repeat (5) @(negedge clk);
    check("R9 start ignored in error", err, 1);
    check("R9 no strobes in error", ncap, 0);
    @(posedge clk); #1 rst = 1'b1;
    @(posedge clk); #1 rst = 1'b0;
    cfg_busy = 1'b0;
    @(negedge clk);
    check("R13 reset clears err", err, 0);
    check("R13 idle after reset", busy, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    t_reset();
    run_load("basic",  12, 24'h0001F8, 0, 4, 1'b0);
    run_load("alt",    20, 24'h000300, 1, 2, 1'b0);  // R6
    run_load("burst",  30, 24'h00FFF0, 2, 6, 1'b0);  // R6
    run_load("zero",    0, 24'h000010, 0, 1, 1'b0);  // R10
    run_load("latch",  10, 24'h000050, 2, 3, 1'b1);  // R9 R12
    t_timeout();
    run_load("after",   5, 24'h000777, 1, 2, 1'b0);  // R13
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    wait (cyc > 20000);
    fails++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule